// File: doc/BRIEF.md
# Signed Integer Divider Unit

This block is a multi-cycle signed divider for an integer execution pipeline. It receives a 32-bit instruction word together with two operand values. It checks whether the word is the signed-divide encoding. If it is, the block divides the first operand by the second and returns the quotient and the remainder with a one-cycle completion strobe. The register indices carried by the instruction are returned with the result. The divider has no trap path. Each corner case produces a defined result.

The datapath works on magnitudes. A restoring shift-subtract core produces one quotient bit per cycle. A final cycle then applies the signs, so the quotient rounds toward zero. A zero divisor and the most-negative value divided by minus one are both detected at issue. They complete in a single cycle without entering the iterative core. The pipeline starts an operation with a one-cycle start pulse. A start pulse that arrives while the unit is busy is dropped.

Top module: `sdiv_unit`

## Requirements
- R1: A start is accepted only when instruction bits 6..0 equal 0110011, bits 14..12 equal 100 and bits 31..25 equal 0000001. Any other word accepted while idle sets illegal_o for exactly the next cycle, leaves busy_o low and produces no done_o.
- R2: For a nonzero divisor outside the overflow case, quot_o is the true quotient truncated toward zero. Its sign is the XOR of the operand signs, and it is zero when the magnitude quotient is zero.
- R3: For a nonzero divisor outside the overflow case, rem_o equals dividend − quot_o × divisor, and its sign follows the dividend.
- R4: With a divisor of zero, quot_o is all ones and rem_o equals the dividend. done_o rises in the cycle after the accepting edge, and busy_o stays low.
- R5: With a dividend of 0x80000000 and a divisor of 0xFFFFFFFF, quot_o equals the dividend and rem_o is zero. The result arrives in the cycle after the accepting edge, and busy_o stays low.
- R6: A normal divide raises busy_o from the cycle after acceptance. done_o rises XLEN+2 cycles after the accepting edge, in the same cycle that busy_o falls.
- R7: done_o is high for exactly one cycle per completed operation.
- R8: A start pulse presented while busy_o is high is ignored. The running result, its indices and its timing are unchanged, and no extra done_o follows.
- R9: rd_o, rs1_idx_o and rs2_idx_o present instruction bits 11..7, 19..15 and 24..20 of the accepted divide. They are valid with done_o and held until the next accepted divide.
- R10: After reset, busy_o, done_o and illegal_o are low and quot_o and rem_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue pulse, sampled only while idle |
| instr_i | input | 32 | Instruction word to decode |
| rs1_val_i | input | XLEN | Dividend value |
| rs2_val_i | input | XLEN | Divisor value |
| busy_o | output | 1 | Iterative divide in progress |
| done_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | One-cycle flag for a non-divide word |
| quot_o | output | XLEN | Signed quotient |
| rem_o | output | XLEN | Signed remainder |
| rd_o | output | 5 | Destination index of the result |
| rs1_idx_o | output | 5 | First source index |
| rs2_idx_o | output | 5 | Second source index |

## Verification
The bench builds the unit with the default XLEN of 32. At that width the iteration count is a full 32 steps, and the overflow pattern 0x80000000 / 0xFFFFFFFF is the real architectural corner case. Random operands are skewed toward zero, minus one, the most-negative value and small magnitudes. This brings truncation of negative quotients, zero quotients and both bypass paths within reach alongside full-width magnitudes. Directed sequences add illegal encodings and a start pulse injected in the middle of a running divide.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam logic [6:0] OPC_REG_OP = 7'b0110011;
  localparam logic [2:0] F3_SDIV    = 3'b100;
  localparam logic [6:0] F7_MULDIV  = 7'b0000001;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIX
  } state_e;

  typedef struct packed {
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } reg_idx_t;
endpackage

// File: rtl/sdiv_decode.sv
module sdiv_decode
  import sdiv_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic        legal_o,
  output reg_idx_t    idx_o
);
  always_comb begin
    legal_o   = (instr_i[6:0] == OPC_REG_OP) &&
                (instr_i[14:12] == F3_SDIV) &&
                (instr_i[31:25] == F7_MULDIV);
    idx_o.rd  = instr_i[11:7];
    idx_o.rs1 = instr_i[19:15];
    idx_o.rs2 = instr_i[24:20];
  end
endmodule

// File: rtl/sdiv_sign_prep.sv
module sdiv_sign_prep #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic [XLEN-1:0] dvd_mag_o,
  output logic [XLEN-1:0] dvs_mag_o,
  output logic            q_neg_o,
  output logic            r_neg_o,
  output logic            div_zero_o,
  output logic            ovf_o
);
  localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

  always_comb begin
    // the most-negative magnitude still fits as an unsigned XLEN value
    dvd_mag_o  = dvd_i[XLEN-1] ? (~dvd_i + 1'b1) : dvd_i;
    dvs_mag_o  = dvs_i[XLEN-1] ? (~dvs_i + 1'b1) : dvs_i;
    q_neg_o    = dvd_i[XLEN-1] ^ dvs_i[XLEN-1];
    r_neg_o    = dvd_i[XLEN-1];
    div_zero_o = (dvs_i == '0);
    ovf_o      = (dvd_i == MOST_NEG) && (dvs_i == '1);
  end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] dvd_i,
  input  logic [XLEN-1:0] dvs_i,
  output logic            last_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o
);
  localparam int unsigned CW = $clog2(XLEN + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(XLEN - 1);

  logic [XLEN-1:0] acc_q, rem_q, dvs_q;
  logic [CW-1:0]   cnt_q;
  logic [XLEN:0]   shifted, trial;
  logic            qbit;

  always_comb begin
    shifted = {rem_q, acc_q[XLEN-1]};
    trial   = shifted - {1'b0, dvs_q};
    qbit    = ~trial[XLEN];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      acc_q <= dvd_i;
      rem_q <= '0;
      dvs_q <= dvs_i;
      cnt_q <= '0;
    end else if (step_i) begin
      acc_q <= {acc_q[XLEN-2:0], qbit};
      rem_q <= qbit ? trial[XLEN-1:0] : shifted[XLEN-1:0];
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last_o = (cnt_q == LAST_CNT);
  assign quot_o = acc_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] q_mag_i,
  input  logic [XLEN-1:0] r_mag_i,
  input  logic            q_neg_i,
  input  logic            r_neg_i,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o
);
  always_comb begin
    quot_o = q_neg_i ? (~q_mag_i + 1'b1) : q_mag_i;
    rem_o  = r_neg_i ? (~r_mag_i + 1'b1) : r_mag_i;
  end
endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit
  import sdiv_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o,
  output logic [4:0]      rd_o,
  output logic [4:0]      rs1_idx_o,
  output logic [4:0]      rs2_idx_o
);
  state_e          state_q;
  logic            legal, div_zero, ovf, q_neg, r_neg;
  logic            q_neg_q, r_neg_q;
  reg_idx_t        idx, idx_q;
  logic [XLEN-1:0] dvd_mag, dvs_mag;
  logic [XLEN-1:0] core_q, core_r, fix_q, fix_r;
  logic [XLEN-1:0] quot_q, rem_q;
  logic            done_q, ill_q, core_last;
  logic            accept, special, core_load, core_step;

  sdiv_decode u_dec (
    .instr_i (instr_i),
    .legal_o (legal),
    .idx_o   (idx)
  );

  sdiv_sign_prep #(.XLEN(XLEN)) u_prep (
    .dvd_i      (rs1_val_i),
    .dvs_i      (rs2_val_i),
    .dvd_mag_o  (dvd_mag),
    .dvs_mag_o  (dvs_mag),
    .q_neg_o    (q_neg),
    .r_neg_o    (r_neg),
    .div_zero_o (div_zero),
    .ovf_o      (ovf)
  );

  assign accept    = start_i && (state_q == ST_IDLE);
  assign special   = div_zero || ovf;
  assign core_load = accept && legal && !special;
  assign core_step = (state_q == ST_RUN);

  sdiv_core #(.XLEN(XLEN)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (core_load),
    .step_i (core_step),
    .dvd_i  (dvd_mag),
    .dvs_i  (dvs_mag),
    .last_o (core_last),
    .quot_o (core_q),
    .rem_o  (core_r)
  );

  sdiv_fixup #(.XLEN(XLEN)) u_fix (
    .q_mag_i (core_q),
    .r_mag_i (core_r),
    .q_neg_i (q_neg_q),
    .r_neg_i (r_neg_q),
    .quot_o  (fix_q),
    .rem_o   (fix_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      q_neg_q <= 1'b0;
      r_neg_q <= 1'b0;
      idx_q   <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (!legal) begin
              ill_q <= 1'b1;
            end else begin
              idx_q <= idx;
              if (div_zero) begin
                quot_q <= '1;
                rem_q  <= rs1_val_i;
                done_q <= 1'b1;
              end else if (ovf) begin
                quot_q <= rs1_val_i;
                rem_q  <= '0;
                done_q <= 1'b1;
              end else begin
                q_neg_q <= q_neg;
                r_neg_q <= r_neg;
                state_q <= ST_RUN;
              end
            end
          end
        end
        ST_RUN: begin
          if (core_last) state_q <= ST_FIX;
        end
        ST_FIX: begin
          quot_q  <= fix_q;
          rem_q   <= fix_r;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign illegal_o = ill_q;
  assign quot_o    = quot_q;
  assign rem_o     = rem_q;
  assign rd_o      = idx_q.rd;
  assign rs1_idx_o = idx_q.rs1;
  assign rs2_idx_o = idx_q.rs2;
endmodule

// File: rtl/sdiv_unit_chk.sv
module sdiv_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] rs2_val_i,
  input logic [XLEN-1:0] quot_o,
  input logic [XLEN-1:0] rem_o,
  input logic [4:0]      rd_o
);
  a_r1_illegal_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!done_o && !busy_o));

  a_r4_zero_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(busy_o) && ($past(rs2_val_i) == '0)) |-> (quot_o == '1));

  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(busy_o) && ($past(rs2_val_i) != '0))
      |-> ((rem_o == '0) && (quot_o == $past(rs1_val_i))));

  a_r6_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_idx_stable_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_o));
endmodule

bind sdiv_unit sdiv_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .illegal_o (illegal_o),
  .rs1_val_i (rs1_val_i),
  .rs2_val_i (rs2_val_i),
  .quot_o    (quot_o),
  .rem_o     (rem_o),
  .rd_o      (rd_o)
);

// File: tb/sdiv_unit_bench.sv
`timescale 1ns/1ps
module sdiv_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] MIN_NEG = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] instr = '0, a_in = '0, b_in = '0;
  logic busy, done, illegal;
  logic [31:0] quot, rem;
  logic [4:0] rd, rs1i, rs2i;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  sdiv_unit #(.XLEN(XLEN)) u_sdiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .instr_i(instr),
    .rs1_val_i(a_in), .rs2_val_i(b_in), .busy_o(busy), .done_o(done),
    .illegal_o(illegal), .quot_o(quot), .rem_o(rem), .rd_o(rd),
    .rs1_idx_o(rs1i), .rs2_idx_o(rs2i)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_div(input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2);
    return {7'b0000001, s2, s1, 3'b100, d, 7'b0110011};
  endfunction

  function automatic logic [31:0] exp_q(input logic signed [31:0] a, input logic signed [31:0] b);
    if (b == 0) return '1;
    if (a == MIN_NEG && b == -1) return a;
    return a / b;
  endfunction

  function automatic logic [31:0] exp_r(input logic signed [31:0] a, input logic signed [31:0] b);
    if (b == 0) return a;
    if (a == MIN_NEG && b == -1) return '0;
    return a % b;
  endfunction

  // issue a legal divide; optionally inject a start at wait cycle inj_at
  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input logic [4:0] d,
                         input logic [4:0] s1, input logic [4:0] s2, input int inj_at);
    int lat;
    int exp_lat;
    bit spec;
    spec = (b == 0) || (a == MIN_NEG && b == '1);
    exp_lat = spec ? 1 : XLEN + 2;
    @(negedge clk);
    start = 1'b1; instr = mk_div(d, s1, s2); a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; lat = 1;
    if (spec) check(!busy, "R4/R5 busy low on bypass", 64'(busy), 0);
    else check(busy, "R6 busy after accept", 64'(busy), 1);
    while (!done && lat < 100) begin
      if (lat == inj_at) begin
        start = 1'b1; instr = mk_div(5'd31, 5'd30, 5'd29); a_in = 32'd5; b_in = 32'd0;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat == exp_lat, "R6 latency", 64'(lat), 64'(exp_lat));
    if (!spec) check(!busy, "R6 busy falls with done", 64'(busy), 0);
    if (b == 0) begin
      check(quot == '1, "R4 quotient", 64'(quot), 64'hFFFF_FFFF);
      check(rem == a, "R4 remainder", 64'(rem), 64'(a));
    end else if (spec) begin
      check(quot == a, "R5 quotient", 64'(quot), 64'(a));
      check(rem == 0, "R5 remainder", 64'(rem), 0);
    end else begin
      check(quot == exp_q(a, b), "R2 quotient", 64'(quot), 64'(exp_q(a, b)));
      check(rem == exp_r(a, b), "R3 remainder", 64'(rem), 64'(exp_r(a, b)));
    end
    check({rd, rs1i, rs2i} == {d, s1, s2}, "R9 indices", 64'({rd, rs1i, rs2i}), 64'({d, s1, s2}));
    @(negedge clk);
    check(!done, "R7 done single cycle", 64'(done), 0);
    check({rd, rs1i, rs2i} == {d, s1, s2}, "R9 indices held", 64'({rd, rs1i, rs2i}), 64'({d, s1, s2}));
  endtask

  task automatic run_illegal(input logic [31:0] ins);
    @(negedge clk);
    start = 1'b1; instr = ins; a_in = 32'd100; b_in = 32'd3;
    @(negedge clk);
    start = 1'b0;
    check(illegal && !busy && !done, "R1 illegal flagged", 64'({illegal, busy, done}), 64'b100);
    @(negedge clk);
    check(!illegal, "R1 illegal one cycle", 64'(illegal), 0);
    for (int i = 0; i < 4; i++) begin
      check(!done && !busy, "R1 no start on illegal", 64'({busy, done}), 0);
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] pick_val(input int sel);
    logic [31:0] r;
    r = $urandom;
    case (sel)
      0: return 32'd0;
      1: return '1;
      2: return MIN_NEG;
      3, 4: return {{24{r[31]}}, r[7:0]};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    check(!busy && !done && !illegal && quot == 0 && rem == 0, "R10 reset state",
          64'({busy, done, illegal, |quot, |rem}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !illegal, "R10 after release", 64'({busy, done, illegal}), 0);

    run_div(32'd100, 32'd7, 5'd1, 5'd2, 5'd3, -1);           // R2 basic
    run_div(-32'sd100, 32'd7, 5'd4, 5'd5, 5'd6, -1);         // R2 trunc toward zero
    run_div(32'd100, -32'sd7, 5'd7, 5'd8, 5'd9, -1);
    run_div(-32'sd7, -32'sd100, 5'd10, 5'd11, 5'd12, -1);    // R2 zero quotient, R3 rem sign
    run_div(MIN_NEG, 32'd1, 5'd13, 5'd14, 5'd15, -1);
    run_div(MIN_NEG, 32'd2, 5'd13, 5'd14, 5'd15, -1);
    run_div(32'h7FFF_FFFF, '1, 5'd16, 5'd17, 5'd18, -1);
    run_div(-32'sd42, 32'd0, 5'd19, 5'd20, 5'd21, -1);       // R4
    run_div(32'd0, 32'd0, 5'd22, 5'd23, 5'd24, -1);          // R4
    run_div(MIN_NEG, '1, 5'd25, 5'd26, 5'd27, -1);           // R5
    run_div(32'd1000, 32'd7, 5'd3, 5'd4, 5'd5, 3);           // R8 injected start
    check(!done && !busy, "R8 no extra done", 64'({busy, done}), 0);
    run_div(MIN_NEG, '1, 5'd1, 5'd1, 5'd1, -1);              // back-to-back after R8

    run_illegal({7'b0000000, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011}); // R1 funct7
    run_illegal({7'b0000001, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0110011}); // R1 funct3
    run_illegal({7'b0000001, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0111011}); // R1 opcode

    for (int n = 0; n < 300; n++) begin
      logic [31:0] ra, rb, ri;
      ra = pick_val($urandom_range(0, 9));
      rb = pick_val($urandom_range(0, 9));
      ri = $urandom;
      run_div(ra, rb, ri[4:0], ri[9:5], ri[14:10], -1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule